// File: doc/BRIEF.md
# Enable-Gated Compare Timer

This block pairs a free-running system counter with a compare register and reports a timer condition whenever the timer is switched on and the counter has caught up with the compare value. The counter advances by one on each clock cycle in which the increment strobe is high. It keeps running whatever the timer's control bits say. The condition drives a status bit and a level-sensitive interrupt, and the interrupt can be silenced by a mask bit.

The counter width `CNT_W` is a parameter of at most 64 bits. The compare register is built at that same width. Its bits above `CNT_W` read as zero, and every comparison treats both operands as unsigned values zero-extended to 64 bits. Software uses one write port and one combinational read port, each with a 2-bit select: 0 for the compare value, 1 for the counter (read-only), 2 for control, and 3 for an unused slot that reads zero.

Top module: `gated_cmp_timer`

## Requirements
- R1: After reset the compare value, the counter, the enable bit and the mask bit are all 0, and `cond_o` and `irq_o` are low.
- R2: The counter rises by exactly one after each clock edge at which `tick_i` is high, keeps its value when `tick_i` is low, and wraps from 2^CNT_W-1 to 0.
- R3: The counter advances the same way whether the enable bit is 0 or 1.
- R4: With enable at 1, `cond_o` is high exactly when the unsigned counter value is greater than or equal to the unsigned compare value.
- R5: With enable at 0, `cond_o` is low for every counter and compare value.
- R6: Reading select 0 returns the stored compare value. Write-data bits at and above `CNT_W` are dropped, and those bit positions read as 0.
- R7: A write to select 0 is used by the comparison from the first cycle after the write edge. Moving the compare value above the counter drops `cond_o` and `irq_o` in that same cycle.
- R8: The control word read at select 2 holds enable in bit 0, mask in bit 1 and status (equal to `cond_o`) in bit 2, with every other bit 0. A write to select 2 loads bits 0 and 1 only, and the status bit ignores written data.
- R9: `irq_o` equals status AND NOT mask. The mask bit never changes the status bit or `cond_o`.
- R10: A write to select 1 leaves the counter unchanged. Reading select 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter increment strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 compare, 1 counter (ignored), 2 control |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 2 | Read select: 0 compare, 1 counter, 2 control, 3 zero |
| rd_data_o | output | 64 | Combinational read data, zero-extended |
| cond_o | output | 1 | Timer condition (status) |
| irq_o | output | 1 | Level interrupt, status AND NOT mask |

## Verification
A counter that skips, stalls or fails to wrap is visible on the counter read port in the very cycle after the faulty edge. It also shifts the cycle in which `cond_o` first rises during a sweep. A compare register holding stray upper bits, or one that loads late, shows up as a wrong readback or as a condition that is one cycle late or never comes. A lost or inverted mask or enable shows at once in the relationship between `irq_o`, `cond_o` and the control readback. The bench uses a 4-bit counter, so every compare value can be swept against every counter value with both mask settings.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int unsigned DATA_W = 64;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MASK_BIT = 1;
  localparam int unsigned CTL_STAT_BIT = 2;

  // Ones in the implemented low bits of a word of width w.
  function automatic word_t low_mask(int unsigned w);
    if (w >= DATA_W) return '1;
    return (word_t'(1) << w) - word_t'(1);
  endfunction

  // Keep only the implemented bits of a written value.
  function automatic word_t clip(word_t v, int unsigned w);
    return v & low_mask(w);
  endfunction

  // Timer condition on zero-extended operands.
  function automatic logic cond_met(logic en, word_t cnt, word_t cmp);
    return en && (cnt >= cmp);
  endfunction

endpackage

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_inc;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tc_regs.sv
module tc_regs
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  word_t            wr_data_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             en_o,
  output logic             mask_o
);

  logic [CNT_W-1:0] cmp_q;
  logic             en_q;
  logic             mask_q;
  logic             wr_cmp;
  logic             wr_ctl;
  word_t            wr_clipped;

  assign wr_cmp     = wr_en_i && (sel_e'(wr_sel_i) == SEL_CMP);
  assign wr_ctl     = wr_en_i && (sel_e'(wr_sel_i) == SEL_CTL);
  assign wr_clipped = clip(wr_data_i, CNT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_cmp) begin
      cmp_q <= wr_clipped[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_ctl) begin
      en_q   <= wr_data_i[CTL_EN_BIT];
      mask_q <= wr_data_i[CTL_MASK_BIT];
    end
  end

  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/tc_compare.sv
module tc_compare
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  input  logic             mask_i,
  output logic             hit_o,
  output logic             status_o,
  output logic             irq_o
);

  word_t cnt_ext;
  word_t cmp_ext;

  assign cnt_ext  = word_t'(cnt_i);
  assign cmp_ext  = word_t'(cmp_i);
  assign hit_o    = cnt_ext >= cmp_ext;
  assign status_o = cond_met(en_i, cnt_ext, cmp_ext);
  assign irq_o    = status_o && !mask_i;

endmodule

// File: rtl/gated_cmp_timer.sv
module gated_cmp_timer
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [63:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [63:0] rd_data_o,
  output logic        cond_o,
  output logic        irq_o
);

  // Named internal wires, also watched by the bound checker.
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             en_q;
  logic             mask_q;
  logic             cmp_hit;
  logic             status;
  word_t            ctl_word;

  tc_counter #(.CNT_W(CNT_W)) counter_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .cnt_o  (cnt_q)
  );

  tc_regs #(.CNT_W(CNT_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .cmp_o     (cmp_q),
    .en_o      (en_q),
    .mask_o    (mask_q)
  );

  tc_compare #(.CNT_W(CNT_W)) compare_i (
    .cnt_i    (cnt_q),
    .cmp_i    (cmp_q),
    .en_i     (en_q),
    .mask_i   (mask_q),
    .hit_o    (cmp_hit),
    .status_o (status),
    .irq_o    (irq_o)
  );

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_EN_BIT]   = en_q;
    ctl_word[CTL_MASK_BIT] = mask_q;
    ctl_word[CTL_STAT_BIT] = status;
  end

  always_comb begin
    unique case (sel_e'(rd_sel_i))
      SEL_CMP: rd_data_o = word_t'(cmp_q);
      SEL_CNT: rd_data_o = word_t'(cnt_q);
      SEL_CTL: rd_data_o = ctl_word;
      default: rd_data_o = '0;
    endcase
  end

  assign cond_o = status;

endmodule

// File: rtl/tc_checker.sv
module tc_checker
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [63:0]      wr_data_i,
  input logic [1:0]       rd_sel_i,
  input logic [63:0]      rd_data_o,
  input logic             cond_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             en_q,
  input logic             mask_q,
  input logic             cmp_hit
);

  // R2: one step per strobe, wrapping at the counter width
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

  // R2, R3: no strobe, no movement, whatever the enable bit
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // R4: enabled and counter caught up means condition high
  a_r4_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && (word_t'(cnt_q) >= word_t'(cmp_q))) |-> cond_o);

  // R4: counter below compare means condition low
  a_r4_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (word_t'(cnt_q) < word_t'(cmp_q)) |-> !cond_o);

  // R5: disabled timer never reports the condition
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !cond_o);

  // R6: no implemented-width overflow on compare readback
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_i == 2'd0) |-> ((rd_data_o & ~low_mask(CNT_W)) == '0));

  // R7: compare write lands at the next edge
  a_r7_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd0) |=> cmp_q == $past(wr_data_i[CNT_W-1:0]));

  // R9: interrupt level follows status and mask
  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (cond_o && !mask_q));

  // R10: counter select is not writable
  a_r10_cnt_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 2'd1 && !tick_i) |=> $stable(cnt_q));

  // R4: raw comparison agrees with condition when enabled
  a_r4_hit_wire: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cond_o == cmp_hit));

endmodule

bind gated_cmp_timer tc_checker #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/gated_cmp_timer_tb_top.sv
module gated_cmp_timer_tb_top;

  localparam int W   = 4;
  localparam int MOD = 1 << W;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [63:0] wr_data_i;
  logic [1:0]  rd_sel_i;
  logic [63:0] rd_data_o;
  logic        cond_o;
  logic        irq_o;

  int n_checks = 0;
  int n_err    = 0;
  int exp_cnt  = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  gated_cmp_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .cond_o(cond_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] sel, logic [63:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic do_read(logic [1:0] sel, output logic [63:0] data);
    rd_sel_i = sel;
    #1;
    data = rd_data_o;
  endtask

  task automatic step(bit t);
    @(negedge clk);
    tick_i = t;
    @(negedge clk);
    tick_i = 1'b0;
    if (t) exp_cnt = (exp_cnt + 1) % MOD;
  endtask

  // Condition, interrupt, status bit and counter against the arithmetic model.
  task automatic check_state(string req, bit en, bit mask, int cmp);
    logic [63:0] d;
    bit exp_c;
    exp_c = en && (exp_cnt >= cmp);
    do_read(2'd1, d);
    chk({req, " counter"}, d, 64'(exp_cnt));
    chk({req, " cond"}, 64'(cond_o), 64'(exp_c));
    chk({req, " irq"}, 64'(irq_o), 64'(exp_c && !mask));
    do_read(2'd2, d);
    chk({req, " ctl"}, d, 64'({exp_c, mask, en}));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = '0;
    wr_data_i = '0; rd_sel_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1: reset state
    do_read(2'd0, d); chk("R1 cmp", d, 64'd0);
    do_read(2'd1, d); chk("R1 cnt", d, 64'd0);
    do_read(2'd2, d); chk("R1 ctl", d, 64'd0);
    chk("R1 cond", 64'(cond_o), 64'd0);
    chk("R1 irq", 64'(irq_o), 64'd0);

    // R2, R3, R5: counting with the timer disabled, condition stays low
    for (int i = 0; i < MOD + 3; i++) begin
      step(1'b1);
      check_state("R2_R3_R5 count", 1'b0, 1'b0, 0);
    end
    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      check_state("R2 hold", 1'b0, 1'b0, 0);
    end
    while (exp_cnt != MOD - 1) step(1'b1);
    step(1'b1);
    do_read(2'd1, d); chk("R2 wrap", d, 64'd0);

    // R4, R9, R3: full sweep of compare against counter, both masks
    for (int m = 0; m < 2; m++) begin
      do_write(2'd2, 64'(2 * m + 1));
      for (int c = 0; c < MOD; c++) begin
        do_write(2'd0, 64'(c));
        check_state("R4_R9 sweep", 1'b1, m[0], c);
        for (int k = 0; k < MOD; k++) begin
          step(1'b1);
          check_state("R3_R4_R9 sweep", 1'b1, m[0], c);
        end
      end
    end

    // R6: upper write bits dropped, read as zero
    do_write(2'd0, 64'hDEAD_BEEF_0000_00A7);
    do_read(2'd0, d); chk("R6 clip", d, 64'h7);
    do_write(2'd0, 64'hFFFF_FFFF_FFFF_FFF0);
    do_read(2'd0, d); chk("R6 clip zero", d, 64'h0);

    // R7: compare moved above counter drops cond and irq in the next cycle
    do_write(2'd2, 64'h1);
    do_write(2'd0, 64'h0);
    while (exp_cnt >= MOD - 1) step(1'b1);
    chk("R7 before", 64'(irq_o), 64'd1);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 64'(MOD - 1);
    #1;
    chk("R7 pre-edge cond", 64'(cond_o), 64'd1);
    @(negedge clk);
    wr_en_i = 1'b0;
    chk("R7 cond drop", 64'(cond_o), 64'd0);
    chk("R7 irq drop", 64'(irq_o), 64'd0);

    // R8: status bit not writable, spare bits read zero
    do_write(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    do_read(2'd2, d); chk("R8 ctl all ones", d, 64'h3);
    do_write(2'd0, 64'h0);
    do_read(2'd2, d); chk("R8 status up", d, 64'h6 | 64'h1);
    chk("R9 masked irq", 64'(irq_o), 64'd0);
    do_write(2'd2, 64'h4);
    do_read(2'd2, d); chk("R8 status write ignored", d, 64'h0);

    // R10: counter select read-only, select 3 reads zero
    d = 64'(exp_cnt);
    do_write(2'd1, 64'h9 ^ d);
    do_read(2'd1, d); chk("R10 cnt ro", d, 64'(exp_cnt));
    do_read(2'd3, d); chk("R10 sel3", d, 64'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule